// File: doc/BRIEF.md
# NAND Sector ECC Status and Fix Engine

This block sits beside the page buffer of a NAND flash read path. An external ECC decoder reports a result for each sector as the sector's decode completes. The result says whether the sector is uncorrectable or correctable, and gives the byte address of the faulty word and the syndrome word that repairs it. The block gathers these results into one 32-bit status word. It also keeps the address and the syndrome for each of the eight main-area sectors and each of the four spare-area sectors.

When the read logic asks for a fix, the block works out which sector has just finished. It takes the live page byte counter, divides it by the 256-byte sector size and subtracts one. For a spare-area request it uses the spare slot number given with the request. It then returns one of three results. A fail result means the sector is uncorrectable or the index is illegal. A corrected result means the buffer word was read, XORed with the syndrome and written back. A clean result means the sector needed nothing. A request that arrives while a fix is in progress is held in a one-deep slot and starts when the running fix reports done.

Top module: `nand_ecc_fixer`

## Requirements
- R1: After reset, `status` is zero and `fix_done`, `buf_rd` and `buf_we` are low.
- R2: A `dec_valid` strobe for slot s sets a bit in `status` one cycle later. For a main slot s (0 to 7), `dec_uncorr` sets bit s and `dec_corr` sets bit 16+s. For a spare slot 8+m (m from 0 to 3), they set bits 8+m and 24+m. The strobe also stores the error address and the syndrome for that slot. A strobe with a slot number of 12 or more changes nothing.
- R3: `page_start` clears `status` to zero in the next cycle and discards a decode strobe in the same cycle.
- R4: Status bits are sticky: once set, a bit stays set until `page_start` or reset.
- R5: For a main-area request, the sector index is `byte_cnt/256 - 1`. If `byte_cnt/256` is 0 or greater than 8, the result is fail (2'b11) and the buffer is not accessed.
- R6: The result follows a fixed priority: uncorrectable gives fail (2'b11), otherwise correctable gives corrected (2'b01), otherwise clean (2'b00). Only a corrected result touches the buffer.
- R7: For a corrected result, `buf_rd` is high in the first cycle after the start is accepted, with `buf_addr` = stored byte address >> 2. In the second cycle, `buf_we` is high with `buf_wdata` = `buf_rdata` XOR the syndrome, on the same address.
- R8: A request with `fix_spare` set uses spare slot `fix_spare_sel`, no matter what value `byte_cnt` has.
- R9: `fix_done` pulses for exactly one cycle, two cycles after the edge that accepts the start, and `fix_result` is valid in that cycle.
- R10: A start that arrives while the first fix cycle is running is held, together with the `byte_cnt` it was issued with. It is accepted at the edge that ends the running fix's done cycle, so its `fix_done` comes two cycles after the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_start | input | 1 | New page read begins; clears the status |
| dec_valid | input | 1 | Decoder result strobe |
| dec_sector | input | 4 | Slot of the result: 0-7 main, 8-11 spare |
| dec_uncorr | input | 1 | Sector is uncorrectable |
| dec_corr | input | 1 | Sector is correctable |
| dec_err_addr | input | 12 | Byte address of the faulty word within the page |
| dec_syndrome | input | 32 | XOR mask that repairs the word |
| byte_cnt | input | 12 | Live page byte counter |
| fix_start | input | 1 | Fix request pulse |
| fix_spare | input | 1 | Request targets a spare slot |
| fix_spare_sel | input | 2 | Spare slot number |
| fix_done | output | 1 | Fix finished (one-cycle pulse) |
| fix_result | output | 2 | 00 clean, 01 corrected, 11 fail |
| buf_addr | output | 10 | Buffer word address |
| buf_rd | output | 1 | Buffer read enable; data is expected the next cycle |
| buf_rdata | input | 32 | Buffer read data |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 32 | Buffer write data |
| status | output | 32 | Uncorrectable and correctable flags per slot |

## Verification
A decode strobe shows in `status` one cycle after its sampling edge. A fix request accepted at edge E asserts `buf_rd` in the cycle after E and asserts `fix_done`, `fix_result` and `buf_wdata` in the cycle after that. The repaired word is in the buffer model one edge later. The bench drives every input on a falling edge and samples each output on the falling edge of the exact cycle where the result is due. It also checks that `fix_done` and `buf_rd` are low in the cycles around it. A held request is checked by confirming that its done pulse comes exactly two cycles after the first request's done pulse.

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer #(
  parameter int SECT_BYTES = 256,
  parameter int MAIN_N     = 8,
  parameter int SPARE_N    = 4,
  parameter int CNT_W      = 12,
  parameter int WORD_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       page_start,
  input  logic                       dec_valid,
  input  logic [$clog2(MAIN_N+SPARE_N)-1:0] dec_sector,
  input  logic                       dec_uncorr,
  input  logic                       dec_corr,
  input  logic [CNT_W-1:0]           dec_err_addr,
  input  logic [WORD_W-1:0]          dec_syndrome,
  input  logic [CNT_W-1:0]           byte_cnt,
  input  logic                       fix_start,
  input  logic                       fix_spare,
  input  logic [$clog2(SPARE_N)-1:0] fix_spare_sel,
  output logic                       fix_done,
  output logic [1:0]                 fix_result,
  output logic [CNT_W-3:0]           buf_addr,
  output logic                       buf_rd,
  input  logic [WORD_W-1:0]          buf_rdata,
  output logic                       buf_we,
  output logic [WORD_W-1:0]          buf_wdata,
  output logic [31:0]                status
);
  localparam int SH     = $clog2(SECT_BYTES);
  localparam int TOT    = MAIN_N + SPARE_N;
  localparam int SLOT_W = $clog2(TOT);
  localparam int SEL_W  = $clog2(SPARE_N);
  localparam int WA_W   = CNT_W - 2;

  localparam logic [1:0] RES_CLEAN = 2'b00;
  localparam logic [1:0] RES_FIXED = 2'b01;
  localparam logic [1:0] RES_FAIL  = 2'b11;

  function automatic logic [4:0] slot_lane(input logic [SLOT_W-1:0] s);
    if (int'(s) < MAIN_N) return 5'(s);
    return 5'(int'(s) - MAIN_N + 8);
  endfunction

  logic [31:0]       status_r;
  logic [WA_W-1:0]   ewaddr [TOT];
  logic [WORD_W-1:0] esyn   [TOT];
  logic              unused_lsb;
  assign unused_lsb = ^dec_err_addr[1:0];

  logic dec_take;
  assign dec_take = dec_valid && !page_start && (int'(dec_sector) < TOT);

  logic [4:0] dec_lane;
  assign dec_lane = slot_lane(dec_sector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_r <= '0;
    else if (page_start) status_r <= '0;
    else if (dec_take) begin
      if (dec_uncorr) status_r[dec_lane] <= 1'b1;
      if (dec_corr)   status_r[5'd16 + dec_lane] <= 1'b1;
    end
  end

  for (genvar g = 0; g < TOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ewaddr[g] <= '0;
        esyn[g]   <= '0;
      end else if (dec_take && int'(dec_sector) == g) begin
        ewaddr[g] <= dec_err_addr[CNT_W-1:2];
        esyn[g]   <= dec_syndrome;
      end
    end
  end

  logic             pend, p_spare, ph1, ph2;
  logic [SEL_W-1:0] p_sel;
  logic [CNT_W-1:0] p_cnt;
  logic [1:0]       cur_kind;
  logic [WA_W-1:0]  cur_waddr;
  logic [WORD_W-1:0] cur_syn;

  logic             src_spare;
  logic [SEL_W-1:0] src_sel;
  logic [CNT_W-1:0] src_cnt, q;
  assign src_spare = pend ? p_spare : fix_spare;
  assign src_sel   = pend ? p_sel   : fix_spare_sel;
  assign src_cnt   = pend ? p_cnt   : byte_cnt;
  assign q         = src_cnt >> SH;

  logic              legal;
  logic [SLOT_W-1:0] src_slot, safe_slot;
  logic [4:0]        src_lane;
  logic [1:0]        kind;
  assign legal     = src_spare || (q != '0 && int'(q) <= MAIN_N);
  assign src_slot  = src_spare ? SLOT_W'(MAIN_N) + SLOT_W'(src_sel) : SLOT_W'(q - 1'b1);
  assign safe_slot = (legal && int'(src_slot) < TOT) ? src_slot : '0;
  assign src_lane  = slot_lane(safe_slot);
  assign kind = (!legal || status_r[src_lane]) ? RES_FAIL :
                status_r[5'd16 + src_lane]     ? RES_FIXED : RES_CLEAN;

  logic launch, hold_in;
  assign launch  = (pend || fix_start) && !ph1;
  assign hold_in = fix_start && (pend || ph1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1 <= 1'b0; ph2 <= 1'b0; pend <= 1'b0; p_spare <= 1'b0;
      p_sel <= '0; p_cnt <= '0; cur_kind <= RES_CLEAN;
      cur_waddr <= '0; cur_syn <= '0;
    end else begin
      ph1 <= launch;
      ph2 <= ph1;
      pend <= launch ? (pend && fix_start) : (pend || fix_start);
      if (hold_in) begin
        p_spare <= fix_spare;
        p_sel   <= fix_spare_sel;
        p_cnt   <= byte_cnt;
      end
      if (launch) begin
        cur_kind  <= kind;
        cur_waddr <= ewaddr[safe_slot];
        cur_syn   <= esyn[safe_slot];
      end
    end
  end

  assign status     = status_r;
  assign buf_addr   = cur_waddr;
  assign buf_rd     = ph1 && cur_kind == RES_FIXED;
  assign buf_we     = ph2 && cur_kind == RES_FIXED;
  assign buf_wdata  = buf_rdata ^ cur_syn;
  assign fix_done   = ph2;
  assign fix_result = ph2 ? cur_kind : RES_CLEAN;

  a_r3_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> status == 32'h0);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |=> (status & $past(status)) == $past(status));
  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(buf_rd));
  a_r7_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_addr == $past(buf_addr));
  a_r6_write_only_when_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_done && fix_result != RES_FIXED) |-> !buf_we);
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    fix_done |-> fix_result != 2'b10);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fix_done |=> !fix_done);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(fix_start && pend && ph1));
endmodule

// File: tb/sim_nand_ecc_fixer.sv
`timescale 1ns/1ps
module sim_nand_ecc_fixer;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        page_start = 0, dec_valid = 0, dec_uncorr = 0, dec_corr = 0;
  logic [3:0]  dec_sector = 0;
  logic [11:0] dec_err_addr = 0, byte_cnt = 0;
  logic [31:0] dec_syndrome = 0;
  logic        fix_start = 0, fix_spare = 0;
  logic [1:0]  fix_spare_sel = 0;
  logic        fix_done, buf_rd, buf_we;
  logic [1:0]  fix_result;
  logic [9:0]  buf_addr;
  logic [31:0] buf_rdata, buf_wdata, status;

  nand_ecc_fixer u0 (.*);

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  logic [31:0] mem [1024];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_word(i);
      buf_rdata <= '0;
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_we) mem[buf_addr] <= buf_wdata;
    end
  end

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [31:0] exp_status = 0;
  logic [31:0] exp_mem [1024];
  logic [9:0]  exp_wa  [12];
  logic [31:0] exp_syn [12];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic decode(input int sec, input bit u, input bit c,
                        input logic [11:0] addr, input logic [31:0] syn);
    @(negedge clk);
    dec_valid = 1; dec_sector = 4'(sec); dec_uncorr = u; dec_corr = c;
    dec_err_addr = addr; dec_syndrome = syn;
    @(negedge clk);
    dec_valid = 0;
    if (sec < 12) begin
      if (u) exp_status[sec] = 1'b1;
      if (c) exp_status[16+sec] = 1'b1;
      exp_wa[sec] = addr[11:2];
      exp_syn[sec] = syn;
    end
    chk("R2 status after strobe", status, exp_status);
  endtask

  function automatic logic [1:0] exp_kind(input bit spare, input int sel, input int cnt);
    int qq, slot;
    qq = cnt / 256;
    if (!spare && (qq == 0 || qq > 8)) return 2'b11;
    slot = spare ? 8 + sel : qq - 1;
    if (exp_status[slot]) return 2'b11;
    if (exp_status[16+slot]) return 2'b01;
    return 2'b00;
  endfunction

  function automatic int exp_slot(input bit spare, input int sel, input int cnt);
    return spare ? 8 + sel : cnt / 256 - 1;
  endfunction

  task automatic run_fix(input string req, input bit spare, input int sel, input int cnt);
    logic [1:0] k;
    int slot;
    k = exp_kind(spare, sel, cnt);
    slot = exp_slot(spare, sel, cnt);
    @(negedge clk);
    fix_start = 1; fix_spare = spare; fix_spare_sel = 2'(sel); byte_cnt = 12'(cnt);
    @(negedge clk);
    fix_start = 0;
    chk({req, " R9 no early done"}, 32'(fix_done), 0);
    chk({req, " R7 read strobe"}, 32'(buf_rd), 32'(k == 2'b01));
    if (k == 2'b01) chk({req, " R7 read addr"}, 32'(buf_addr), 32'(exp_wa[slot]));
    @(negedge clk);
    chk({req, " R9 done"}, 32'(fix_done), 1);
    chk({req, " R6 result"}, 32'(fix_result), 32'(k));
    chk({req, " R7 write strobe"}, 32'(buf_we), 32'(k == 2'b01));
    @(negedge clk);
    chk({req, " R9 done one cycle"}, 32'(fix_done), 0);
    if (k == 2'b01) begin
      exp_mem[exp_wa[slot]] ^= exp_syn[slot];
      chk({req, " R7 repaired word"}, mem[exp_wa[slot]], exp_mem[exp_wa[slot]]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R9 watchdog expired got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) exp_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    chk("R1 status reset", status, 0);
    chk("R1 done reset", 32'(fix_done), 0);
    chk("R1 rd/we reset", 32'({buf_rd, buf_we}), 0);
    rst_n = 1;
    @(negedge clk);

    for (int n = 0; n < 12; n++) begin
      int k;
      k = n % 4;
      decode(n, k[1], k[0], 12'(n * 40 + 5), 32'hA5000000 ^ (32'h1 << n));
    end
    decode(13, 1, 1, 12'h7FC, 32'hFFFFFFFF);
    chk("R2 ignored slot leaves status", status, exp_status);
    decode(1, 0, 0, 12'(1 * 40 + 5), 32'hA5000000 ^ 32'h2);
    chk("R4 sticky bits", status, exp_status);

    for (int n = 0; n < 8; n++)
      run_fix("R5 main sweep", 0, 0, (n + 1) * 256 + (n * 37) % 256);
    run_fix("R5 exact boundary", 0, 0, 256 * 2);
    run_fix("R5 top of range", 0, 0, 256 * 9 - 1);
    for (int m = 0; m < 4; m++)
      run_fix("R8 spare sweep", 1, m, 100);
    run_fix("R8 spare ignores counter", 1, 1, 0);
    run_fix("R5 index zero", 0, 0, 100);
    run_fix("R5 index past main", 0, 0, 256 * 9);

    // R10 held request: A on sector 1 (corr), B on sector 5 (corr)
    @(negedge clk);
    fix_start = 1; fix_spare = 0; byte_cnt = 12'(2 * 256);
    @(negedge clk);
    byte_cnt = 12'(6 * 256 + 9);
    @(negedge clk);
    fix_start = 0; byte_cnt = 12'd0;
    chk("R10 first done", 32'(fix_done), 1);
    chk("R10 first result", 32'(fix_result), 32'(2'b01));
    exp_mem[exp_wa[1]] ^= exp_syn[1];
    @(negedge clk);
    chk("R10 gap no done", 32'(fix_done), 0);
    chk("R10 held read uses captured counter", 32'(buf_rd), 1);
    chk("R10 held read addr", 32'(buf_addr), 32'(exp_wa[5]));
    @(negedge clk);
    chk("R10 second done", 32'(fix_done), 1);
    chk("R10 second result", 32'(fix_result), 32'(2'b01));
    exp_mem[exp_wa[5]] ^= exp_syn[5];
    @(negedge clk);
    chk("R10 first word", mem[exp_wa[1]], exp_mem[exp_wa[1]]);
    chk("R10 second word", mem[exp_wa[5]], exp_mem[exp_wa[5]]);

    @(negedge clk);
    page_start = 1; dec_valid = 1; dec_sector = 4'd2; dec_uncorr = 1; dec_corr = 1;
    @(negedge clk);
    page_start = 0; dec_valid = 0;
    exp_status = 0;
    chk("R3 clear and drop strobe", status, 0);
    run_fix("R6 clean after clear", 0, 0, 3 * 256);
    decode(3, 1, 1, 12'd20, 32'h1);
    run_fix("R6 uncorrectable wins", 0, 0, 4 * 256);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule